// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter whose front end is a pair of binary-weighted capacitor arrays. Each conversion is started by one of three sources and then runs through three phases. In the first phase, buffers charge the arrays. In the second, the inputs connect straight to the arrays for a programmable settling window. In the third, the input switches open and sixteen bit trials run, most significant bit first, against an external comparator. The comparator, the capacitor DAC, the reference and the input multiplexer are outside the block. The block only drives their controls and reads the single comparator bit.

A 32-bit configuration word carries three fields. Bits [25:16] give the acquisition length, bits [9:0] give the trigger period in continuous mode, and bit 12 selects differential input. The start source is chosen by a 2-bit mode input: a one-cycle software strobe, a free-running period timer, or a rising edge on an asynchronous pin. Every result is presented with a one-cycle done strobe. The block runs from one 20 MHz clock, so 10 acquisition cycles are 500 ns.

Top module: `sar_seq`

## Requirements
- R1: Every conversion shows `pre_o`, then `acq_o`, then `cnv_o`, in that order. Exactly one of the three is high in every busy cycle, and none is high while idle.
- R2: `pre_o` stays high for exactly 4 cycles per conversion.
- R3: `acq_o` stays high for the number of cycles in `cfg_i[25:16]`, with a value of 0 treated as 1. The field is captured when the start is accepted, so later changes do not affect a running conversion.
- R4: `cnv_o` rises on the same clock edge on which `acq_o` falls.
- R5: Conversion takes 16 trial cycles, MSB first. During a trial, `dac_code_o` equals the bits decided so far with the trial bit added. A bit is kept when `comp_i` is 1 in its trial cycle and cleared otherwise. `dac_code_o` is 0 outside conversion.
- R6: `result_o` updates in the same cycle as a one-cycle `done_o` pulse. `busy_o` is high from the edge that accepts a start for 20 + A cycles, where A is the effective acquisition length. `busy_o` is low while `done_o` is high.
- R7: `trig_mode_i` selects the start source: 2'b00 software strobe `sw_start_i`, 2'b01 continuous timer, 2'b10 external pin, 2'b11 none. Sources that are not selected start nothing.
- R8: In continuous mode, a trigger slot occurs in the first enabled cycle and then every P cycles, where P is `cfg_i[9:0]` and 0 is treated as 1.
- R9: `ext_trig_i` passes through a two-flop synchroniser and acts on its rising edge. If the pin rises before clock edge k, `busy_o` is still low after edge k+1 and is high after edge k+2. A pin held high starts nothing more.
- R10: A start request that arrives while `busy_o` is high is dropped and is not queued.
- R11: `diff_o` takes `cfg_i[12]` when a start is accepted and holds that value until the next accepted start.
- R12: After reset, `busy_o`, `done_o`, `pre_o`, `acq_o`, `cnv_o`, `diff_o`, `dac_code_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 32 | Configuration word: [25:16] acquisition cycles, [12] differential, [9:0] continuous period |
| trig_mode_i | input | 2 | Start source select |
| sw_start_i | input | 1 | Software single-shot strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| comp_i | input | 1 | Comparator: 1 when input is above DAC level |
| pre_o | output | 1 | Precharge buffers drive arrays |
| acq_o | output | 1 | Inputs switched directly onto arrays |
| cnv_o | output | 1 | Conversion active, input switches open |
| diff_o | output | 1 | Differential input select to front end |
| dac_code_o | output | 16 | Capacitor DAC trial code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 16 | Last conversion result |

## Verification
Software conversions run with input levels of zero, one, full scale, exactly mid-scale and two irregular values. Zero and full scale drive every trial the same way. Mid-scale separates a keep decision on the MSB from one on the LSB, and the irregular levels catch a bit taken from the wrong trial. Acquisition settings of 0, 1, 10 and 30 separate the zero-as-one rule from an off-by-one in the window. Continuous runs use a period longer than a conversion, a shorter one and zero, which together separate the timer period from dropped overlapping slots. External-pin cases check the synchroniser delay, that a held level does not retrigger, and that a second edge during a conversion is dropped.

// File: rtl/sar_seq_pkg.sv
// Package: shared phase and trigger-mode types plus configuration
// field positions for the SAR conversion sequencer.
package sar_seq_pkg;

    // Conversion phase of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_ACQ  = 2'd2,
        PH_CONV = 2'd3
    } phase_e;

    // Start source selection.
    typedef enum logic [1:0] {
        TM_SOFT = 2'd0,
        TM_CONT = 2'd1,
        TM_EXT  = 2'd2,
        TM_OFF  = 2'd3
    } trig_mode_e;

    // Configuration word layout.
    localparam int CFG_W    = 32;
    localparam int ACQ_LSB  = 16;
    localparam int ACQ_W    = 10;
    localparam int RATE_LSB = 0;
    localparam int RATE_W   = 10;
    localparam int DIFF_BIT = 12;

endpackage

// File: rtl/sar_trig_unit.sv
// Trigger unit: turns the selected start source into a one-cycle
// start request. It contains the external pin synchroniser with its
// rising-edge detector and the continuous-mode period timer.
// Assumes SYNC_STAGES >= 2 and a request-acceptance decision made
// downstream, so requests that come while busy are simply dropped.
module sar_trig_unit
    import sar_seq_pkg::*;
#(
    parameter int PER_W       = RATE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             sw_start_i,
    input  logic             ext_pin_i,
    input  logic [PER_W-1:0] period_i,
    output logic             req_o
);

    trig_mode_e             mode;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_last_q;
    logic                   ext_rise;
    logic [PER_W-1:0]       rate_q;
    logic                   rate_tick;

    assign mode = trig_mode_e'(mode_i);

    // Synchronise the asynchronous pin and keep one more stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q      <= '0;
            sync_last_q <= 1'b0;
        end else begin
            sync_q      <= {sync_q[SYNC_STAGES-2:0], ext_pin_i};
            sync_last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_last_q;

    // Period timer: a slot in the first enabled cycle, then every period cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else if (mode != TM_CONT) begin
            rate_q <= '0;
        end else if (rate_q == '0) begin
            rate_q <= (period_i == '0) ? '0 : period_i - PER_W'(1);
        end else begin
            rate_q <= rate_q - PER_W'(1);
        end
    end

    assign rate_tick = (mode == TM_CONT) && (rate_q == '0);

    // Pick the request from the selected source only.
    always_comb begin
        case (mode)
            TM_SOFT: req_o = sw_start_i;
            TM_CONT: req_o = rate_tick;
            TM_EXT:  req_o = ext_rise;
            default: req_o = 1'b0;
        endcase
    end

    // R8: a continuous slot never comes while the timer is mid-count.
    a_r8_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_CONT && $past(mode) == TM_CONT && $past(rate_q) > PER_W'(1))
            |-> !rate_tick);

endmodule

// File: rtl/sar_phase_ctl.sv
// Phase controller: accepts a start request when idle, then walks
// precharge (fixed), acquisition (programmable, captured at start)
// and conversion (one cycle per bit). It also captures the input
// mode bit. Assumes acquisition fields of zero mean one cycle.
module sar_phase_ctl
    import sar_seq_pkg::*;
#(
    parameter int AW      = ACQ_W,
    parameter int PRE_CYC = 4,
    parameter int NBITS   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] acq_field_i,
    input  logic          diff_i,
    output phase_e        phase_o,
    output logic          acq_last_o,
    output logic          conv_last_o,
    output logic          diff_o
);

    localparam int NB_W  = $clog2(NBITS + PRE_CYC + 1);
    localparam int CNT_W = (AW > NB_W) ? AW : NB_W;

    phase_e            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [AW-1:0]     acq_len_q;
    logic              diff_q;
    logic              pre_last;
    logic [CNT_W-1:0]  acq_end;

    assign acq_end     = CNT_W'(acq_len_q) - CNT_W'(1);
    assign pre_last    = (ph_q == PH_PRE)  && (cnt_q == CNT_W'(PRE_CYC - 1));
    assign acq_last_o  = (ph_q == PH_ACQ)  && (cnt_q == acq_end);
    assign conv_last_o = (ph_q == PH_CONV) && (cnt_q == CNT_W'(NBITS - 1));

    // Phase sequencing and per-phase cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            cnt_q     <= '0;
            acq_len_q <= '0;
            diff_q    <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (req_i) begin
                        ph_q      <= PH_PRE;
                        cnt_q     <= '0;
                        acq_len_q <= (acq_field_i == '0) ? AW'(1) : acq_field_i;
                        diff_q    <= diff_i;
                    end
                end
                PH_PRE: begin
                    if (pre_last) begin
                        ph_q  <= PH_ACQ;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_ACQ: begin
                    if (acq_last_o) begin
                        ph_q  <= PH_CONV;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_CONV: begin
                    if (conv_last_o) begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = ph_q;
    assign diff_o  = diff_q;

    // R1: acquisition is entered only from precharge.
    a_r1_acq_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ACQ && $past(ph_q) != PH_ACQ) |-> $past(ph_q) == PH_PRE);

    // R1: conversion is entered only from acquisition.
    a_r1_conv_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CONV && $past(ph_q) != PH_CONV) |-> $past(ph_q) == PH_ACQ);

    // R2: precharge had lasted at least four cycles when it ends.
    a_r2_pre_length: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ACQ && $past(ph_q) == PH_PRE) |-> $past(ph_q, 4) == PH_PRE);

    // R10: a new precharge only ever starts from idle.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_PRE && $past(ph_q) != PH_PRE) |-> $past(ph_q) == PH_IDLE);

    // R11: the mode bit only changes when a new conversion begins.
    a_r11_diff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_PRE || $past(ph_q) == PH_PRE) |-> $stable(diff_q));

endmodule

// File: rtl/sar_bit_engine.sv
// Bit engine: successive-approximation register. Armed at the end of
// acquisition, then one trial per cycle from MSB to LSB; the trial
// bit is kept when the comparator reports the input above the DAC.
// Assumes conv_i is high for exactly NBITS cycles after arm_i.
module sar_bit_engine #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             conv_i,
    input  logic             comp_i,
    output logic [NBITS-1:0] dac_code_o,
    output logic [NBITS-1:0] result_o,
    output logic             done_o
);

    localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] mask_q;
    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] result_q;
    logic             done_q;
    logic [NBITS-1:0] trial;

    assign trial = bits_q | mask_q;

    // Trial decision, shift to next bit, final result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            bits_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (arm_i) begin
                mask_q <= TOP_BIT;
                bits_q <= '0;
            end else if (conv_i) begin
                if (comp_i) begin
                    bits_q <= trial;
                end
                mask_q <= mask_q >> 1;
                if (mask_q[0]) begin
                    result_q <= comp_i ? trial : bits_q;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign dac_code_o = conv_i ? trial : '0;
    assign result_o   = result_q;
    assign done_o     = done_q;

    // R5: exactly one trial bit is active during conversion.
    a_r5_one_trial: assert property (@(posedge clk) disable iff (!rst_n)
        conv_i |-> $countones(mask_q) == 1);

    // R5: the first trial is the MSB.
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_i) |-> mask_q[NBITS-1]);

    // R6: done lasts a single cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/sar_seq.sv
// Top: SAR ADC conversion sequencer. Ties the trigger unit, phase
// controller and bit engine together and decodes phase controls for
// the analog front end. Assumes a combinational comparator model
// that follows dac_code_o within the same cycle.
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS       = 16,
    parameter int PRE_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [1:0]       trig_mode_i,
    input  logic             sw_start_i,
    input  logic             ext_trig_i,
    input  logic             comp_i,
    output logic             pre_o,
    output logic             acq_o,
    output logic             cnv_o,
    output logic             diff_o,
    output logic [NBITS-1:0] dac_code_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);

    phase_e phase;
    logic   req;
    logic   acq_last;
    logic   conv_last;

    sar_trig_unit #(
        .PER_W       (RATE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (trig_mode_i),
        .sw_start_i (sw_start_i),
        .ext_pin_i  (ext_trig_i),
        .period_i   (cfg_i[RATE_LSB +: RATE_W]),
        .req_o      (req)
    );

    sar_phase_ctl #(
        .AW      (ACQ_W),
        .PRE_CYC (PRE_CYC),
        .NBITS   (NBITS)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .acq_field_i (cfg_i[ACQ_LSB +: ACQ_W]),
        .diff_i      (cfg_i[DIFF_BIT]),
        .phase_o     (phase),
        .acq_last_o  (acq_last),
        .conv_last_o (conv_last),
        .diff_o      (diff_o)
    );

    sar_bit_engine #(
        .NBITS (NBITS)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (acq_last),
        .conv_i     (cnv_o),
        .comp_i     (comp_i),
        .dac_code_o (dac_code_o),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    // Front-end control decode from the current phase.
    assign pre_o  = (phase == PH_PRE);
    assign acq_o  = (phase == PH_ACQ);
    assign cnv_o  = (phase == PH_CONV);
    assign busy_o = (phase != PH_IDLE);

    // R4: conversion starts on the edge the direct switches open.
    a_r4_cnv_with_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> $fell(acq_o));

    // R6: the final trial of the controller lines up with the engine's done.
    a_r6_done_align: assert property (@(posedge clk) disable iff (!rst_n)
        conv_last |=> done_o);

    // R6: busy is low while the result strobe is shown.
    a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = '0;
    logic [1:0]  mode = 2'd3;
    logic        sw_start = 1'b0;
    logic        ext_pin = 1'b0;
    logic        comp;
    logic        pre, acq, cnv, diff, busy, done;
    logic [15:0] dac_code, result;
    logic [16:0] vin = '0;

    always #4 clk = ~clk;

    // Comparator model: 1 when the input level is above the DAC level.
    assign comp = (vin > {1'b0, dac_code});

    sar_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .trig_mode_i(mode),
        .sw_start_i(sw_start), .ext_trig_i(ext_pin), .comp_i(comp),
        .pre_o(pre), .acq_o(acq), .cnv_o(cnv), .diff_o(diff),
        .dac_code_o(dac_code), .busy_o(busy), .done_o(done), .result_o(result)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [15:0] code;
        int          acq;
        logic        dif;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    function automatic logic [15:0] model(input logic [16:0] v);
        return (v == 17'd0) ? 16'd0 : 16'(v - 17'd1);
    endfunction

    function automatic logic [31:0] mk_cfg(input int a, input int p, input bit d);
        return (32'(a) << 16) | (32'(d) << 12) | 32'(p);
    endfunction

    // Monitor: phase accounting and scoreboard compare at each result.
    int pre_n = 0, acq_n = 0, cnv_n = 0, busy_n = 0;
    logic cnv_p = 0, acq_p = 0, done_p = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(pre) + int'(acq) + int'(cnv) == (busy ? 1 : 0), "R1 phase one-hot",
                int'(pre) + int'(acq) + int'(cnv), busy ? 1 : 0);
            if (!cnv) chk(dac_code == 16'd0, "R5 dac idle", dac_code, 0);
            if (pre) pre_n++;
            if (acq) acq_n++;
            if (cnv) cnv_n++;
            if (busy) busy_n++;
            if (cnv && !cnv_p) begin
                chk(acq_p && !acq, "R4 cnv with acq fall", acq, 0);
                chk(dac_code == 16'h8000, "R5 msb first", dac_code, 16'h8000);
                if (sbq.size() > 0) chk(diff == sbq[0].dif, "R11 diff", diff, sbq[0].dif);
            end
            if (done) begin
                chk(!done_p, "R6 done one cycle", done_p, 0);
                chk(!busy, "R6 busy low at done", busy, 0);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10 unexpected conversion", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(result == e.code, "R5 result", result, e.code);
                    chk(pre_n == 4, "R2 precharge length", pre_n, 4);
                    chk(acq_n == e.acq, "R3 acquisition length", acq_n, e.acq);
                    chk(cnv_n == 16, "R5 trial count", cnv_n, 16);
                    chk(busy_n == 20 + e.acq, "R6 busy length", busy_n, 20 + e.acq);
                end
                pre_n = 0; acq_n = 0; cnv_n = 0; busy_n = 0;
            end
            cnv_p  = cnv;
            acq_p  = acq;
            done_p = done;
        end
    end

    task automatic push(input logic [16:0] v, input int a, input bit d);
        exp_t e;
        e.code = model(v);
        e.acq  = (a == 0) ? 1 : a;
        e.dif  = d;
        sbq.push_back(e);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Driver: one software single-shot conversion.
    task automatic soft_conv(input logic [16:0] v, input int a, input bit d);
        @(negedge clk);
        mode = 2'd0;
        cfg  = mk_cfg(a, 0, d);
        vin  = v;
        push(v, a, d);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        drain();
    endtask

    // Driver: continuous mode, checks spacing of result strobes.
    task automatic cont_run(input int p, input int a, input int n, input int gap, input string req);
        int   got = 0;
        time  last = 0;
        @(negedge clk);
        cfg = mk_cfg(a, p, 1'b0);
        vin = 17'd40000;
        for (int i = 0; i < n; i++) push(17'd40000, a, 1'b0);
        mode = 2'd1;
        while (got < n) begin
            @(negedge clk);
            if (done) begin
                if (got > 0) chk(($time - last) / 8 == gap, req, ($time - last) / 8, gap);
                last = $time;
                got++;
                if (got == n) mode = 2'd3;
            end
        end
        repeat (40) @(negedge clk);
        chk(!busy && sbq.size() == 0, "R7 off after continuous", busy, 0);
    endtask

    // Driver: watch for any conversion for a window.
    task automatic quiet(input int cycles, input string req);
        bit seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state.
        chk({busy, done, pre, acq, cnv, diff} == 6'd0, "R12 reset flags",
            {busy, done, pre, acq, cnv, diff}, 0);
        chk(dac_code == 16'd0 && result == 16'd0, "R12 reset data", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R5: several levels and acquisition lengths.
        soft_conv(17'd0,     10, 1'b0);
        soft_conv(17'd1,     1,  1'b0);
        soft_conv(17'd65536, 30, 1'b0);
        soft_conv(17'd32768, 0,  1'b0);
        soft_conv(17'd23130, 10, 1'b0);
        soft_conv(17'd12345, 7,  1'b0);

        // R11 R3: mode bit and acq length captured at start.
        @(negedge clk);
        mode = 2'd0; cfg = mk_cfg(12, 0, 1'b1); vin = 17'd777;
        push(17'd777, 12, 1'b1);
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        repeat (3) @(negedge clk);
        cfg = mk_cfg(3, 0, 1'b0);
        // R10: second software start while busy is dropped.
        repeat (5) @(negedge clk);
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        drain();
        chk(diff == 1'b1, "R11 diff held after done", diff, 1);
        quiet(40, "R10 busy start dropped");

        // R7: non-selected sources start nothing.
        mode = 2'd3;
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        ext_pin = 1'b1; repeat (4) @(negedge clk); ext_pin = 1'b0;
        quiet(30, "R7 mode none");
        mode = 2'd2;
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
        quiet(30, "R7 soft ignored in ext mode");
        mode = 2'd0;
        ext_pin = 1'b1; repeat (4) @(negedge clk); ext_pin = 1'b0;
        quiet(30, "R7 pin ignored in soft mode");

        // R8 R10: continuous mode spacing.
        cont_run(40, 10, 3, 40, "R8 period 40");
        cont_run(10, 10, 3, 40, "R10 period 10 drops busy slots");
        cont_run(0,  0,  3, 22, "R8 period zero as one");

        // R9: external pin through the synchroniser.
        @(negedge clk);
        mode = 2'd2; cfg = mk_cfg(10, 0, 1'b0); vin = 17'd5000;
        push(17'd5000, 10, 1'b0);
        ext_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk(!busy, "R9 not before sync delay", busy, 0);
        @(negedge clk);
        chk(busy, "R9 start after third edge", busy, 1);
        repeat (8) @(negedge clk);
        ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        ext_pin = 1'b1;  // R10: edge during conversion dropped
        drain();
        quiet(30, "R9 held level no retrigger");
        ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        vin = 17'd60001;
        push(17'd60001, 10, 1'b0);
        ext_pin = 1'b1;
        drain();
        ext_pin = 1'b0;
        chk(result == model(17'd60001), "R9 second edge result", result, model(17'd60001));

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule